// File: doc/BRIEF.md
# Oldest-Candidate Eviction and Relocation Engine

This block finishes a cache miss once a candidate walk has filled its candidate buffer. Each buffer entry points at one line of the tag store (a way number and a slot number) and carries that line's valid bit and last-use timestamp. The entries form an implicit tree with a fixed fan-out. The first `WAYS` entries are the slots that the requested address hashes to, one per way. Every deeper entry is a slot that its parent's line could move into. No parent pointer is stored, because the parent is computed from the index.

On `start`, the engine takes a snapshot of the global timestamp. It then scans the buffer one entry per cycle and picks the victim: the first invalid entry, or else the entry with the greatest modular age. It reports that victim once. It then walks from the victim toward the root. At each step it reads the parent's line from the tag store and writes that line, unchanged, into the slot just freed. Finally it writes the requested tag, stamped with the current time, into the first-level slot at the end of the chain. A 16-bit wrapping counter supplies the time. The counter advances on every external access tick and on every placement.

Top module: `tsv_evict_relocator`

## Requirements
- R1: Reset state. While `rst` is high and in the first cycle after it falls:
  - `busy`, `done`, `evict_valid`, `tag_rd_en` and `tag_wr_en` are low.
  - `now_ts` is 0.
- R2: Timestamp counter.
  - `now_ts` grows by 1 after a cycle with `tick` high and by 1 after a cycle with `done` high, so by 2 when both are high in the same cycle.
  - It stays unchanged after a cycle with neither.
  - It wraps modulo 2^TS_W.
- R3: Victim choice when every candidate is valid.
  - Let `ref` be the value of `now_ts` in the cycle where `start` is accepted.
  - The victim is the entry with the largest `(ref - ts) mod 2^TS_W`.
  - On equal age, the lower buffer index wins.
- R4: Invalid candidates.
  - The lowest-indexed entry whose valid flag is 0 becomes the victim, whatever the ages of the other entries.
  - Its `evict_live` is reported as 0.
- R5: Victim report. `evict_valid` is high for exactly one cycle per operation. In that cycle:
  - `evict_way` and `evict_slot` carry the victim's pointer.
  - `evict_live` carries the victim's valid flag.
- R6: Relocation chain.
  - Entry i with i ≥ WAYS has parent (i − WAYS)/(WAYS − 1).
  - Starting at the victim, while the current entry is not first-level, the parent's line is written with valid, tag and timestamp unchanged into the current entry's slot. The parent then becomes the current entry.
  - The writes happen in order, from the victim toward the root.
- R7: Placement. The last write goes to the first-level entry that ends the chain and carries:
  - valid = 1,
  - the `req_tag` captured at start,
  - the timestamp equal to `now_ts` in that cycle.
- R8: Busy and done.
  - `busy` is high from the cycle after `start` is accepted through the placement cycle.
  - `done` is high only in the placement cycle, together with `tag_wr_en`.
  - In the next cycle `busy` is low.
- R9: Start while busy. `start` asserted while `busy` is high has no effect:
  - no tag change,
  - no further writes,
  - no second operation.
- R10: Tag-store reads.
  - Each relocation write is preceded, in the cycle before it, by a tag-store read of the parent's pointer.
  - The write data is the read data that returns one cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | External cache access; advances the timestamp |
| now_ts | output | TS_W | Current global timestamp |
| cb_wr_en | input | 1 | Candidate buffer write strobe |
| cb_wr_idx | input | IDX_W | Candidate index to write |
| cb_wr_way | input | WAY_W | Way of the candidate line |
| cb_wr_slot | input | SLOT_W | Slot of the candidate line |
| cb_wr_valid | input | 1 | Candidate line holds valid data |
| cb_wr_ts | input | TS_W | Candidate line's last-use timestamp |
| start | input | 1 | Begin victim selection and relocation |
| req_tag | input | TAG_W | Tag of the requested line |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Placement cycle, one-cycle pulse |
| evict_valid | output | 1 | Victim report strobe |
| evict_way | output | WAY_W | Victim way |
| evict_slot | output | SLOT_W | Victim slot |
| evict_live | output | 1 | Victim held a valid line |
| tag_rd_en | output | 1 | Tag-store read request |
| tag_rd_way | output | WAY_W | Read way |
| tag_rd_slot | output | SLOT_W | Read slot |
| tag_rd_valid | input | 1 | Read data: valid, one cycle after request |
| tag_rd_tag | input | TAG_W | Read data: tag |
| tag_rd_ts | input | TS_W | Read data: timestamp |
| tag_wr_en | output | 1 | Tag-store write strobe |
| tag_wr_way | output | WAY_W | Write way |
| tag_wr_slot | output | SLOT_W | Write slot |
| tag_wr_valid | output | 1 | Write data: valid |
| tag_wr_tag | output | TAG_W | Write data: tag |
| tag_wr_ts | output | TS_W | Write data: timestamp |

## Verification
An external access tick can arrive in the same cycle as the placement write, which also advances the counter. The bench provokes this by holding `tick` high through a whole operation. It then checks three things:
- the placed line carries the pre-edge time,
- `now_ts` has jumped by two across that edge,
- the scan still ranked candidates by the snapshot taken at start, not by the moving counter.

A separate run drives the counter past its wrap point, so that a numerically large stamp is the oldest one.

// File: rtl/tsv_pkg.sv
package tsv_pkg;

    // Total entries of an implicit tree with WAYS roots and fan-out WAYS-1.
    function automatic int cand_depth(int ways, int levels);
        int total;
        int width;
        total = 0;
        width = ways;
        for (int l = 0; l < levels; l++) begin
            total += width;
            width *= (ways - 1);
        end
        return total;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_EVICT,
        ST_READ,
        ST_MOVE,
        ST_PLACE
    } phase_e;

endpackage

// File: rtl/tsv_stamp_clock.sv
module tsv_stamp_clock #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            place,
    output logic [TS_W-1:0] now
);

    always_ff @(posedge clk) begin
        if (rst) begin
            now <= '0;
        end else begin
            now <= now + TS_W'(tick) + TS_W'(place);
        end
    end

    // R2: without an event the time stands still
    p_hold_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !place) |=> $stable(now));

    // R2: any event moves the time
    p_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (tick || place) |=> !$stable(now));

endmodule

// File: rtl/tsv_cand_store.sv
module tsv_cand_store #(
    parameter int DEPTH  = 52,
    parameter int IDX_W  = 6,
    parameter int WAY_W  = 2,
    parameter int SLOT_W = 6,
    parameter int TS_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_vld,
    input  logic [TS_W-1:0]   wr_ts,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WAY_W-1:0]  rd_way,
    output logic [SLOT_W-1:0] rd_slot,
    output logic              rd_vld,
    output logic [TS_W-1:0]   rd_ts
);

    typedef struct packed {
        logic              vld;
        logic [TS_W-1:0]   ts;
        logic [SLOT_W-1:0] slot;
        logic [WAY_W-1:0]  way;
    } cand_t;

    cand_t entry_q [DEPTH];
    cand_t rd_ent;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                entry_q[i].vld <= 1'b0;
            end
        end else if (wr_en) begin
            entry_q[wr_idx] <= '{vld: wr_vld, ts: wr_ts, slot: wr_slot, way: wr_way};
        end
    end

    assign rd_ent  = entry_q[rd_idx];
    assign rd_way  = rd_ent.way;
    assign rd_slot = rd_ent.slot;
    assign rd_vld  = rd_ent.vld;
    assign rd_ts   = rd_ent.ts;

endmodule

// File: rtl/tsv_oldest_pick.sv
module tsv_oldest_pick #(
    parameter int IDX_W = 6,
    parameter int TS_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             first,
    input  logic [IDX_W-1:0] idx,
    input  logic [TS_W-1:0]  ref_ts,
    input  logic [TS_W-1:0]  cand_ts,
    output logic [IDX_W-1:0] win_idx
);

    logic [TS_W-1:0]  age;
    logic [TS_W-1:0]  best_age_q;
    logic [IDX_W-1:0] best_idx_q;
    logic             take;

    // Modular age: wrap-safe as long as every stamp is younger than 2^TS_W ticks.
    assign age     = ref_ts - cand_ts;
    // Strictly older replaces; an equal age keeps the earlier (lower) index.
    assign take    = first || (age > best_age_q);
    assign win_idx = take ? idx : best_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            best_age_q <= '0;
            best_idx_q <= '0;
        end else if (step && take) begin
            best_age_q <= age;
            best_idx_q <= idx;
        end
    end

    // R3: the running oldest age never decreases within a scan
    p_best_grows_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !first) |=> (best_age_q >= $past(best_age_q)));

endmodule

// File: rtl/tsv_evict_relocator.sv
module tsv_evict_relocator #(
    parameter int WAYS   = 4,
    parameter int LEVELS = 3,
    parameter int SLOT_W = 6,
    parameter int TAG_W  = 12,
    parameter int TS_W   = 16,
    localparam int DEPTH = tsv_pkg::cand_depth(WAYS, LEVELS),
    localparam int IDX_W = $clog2(DEPTH),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output logic [TS_W-1:0]   now_ts,
    input  logic              cb_wr_en,
    input  logic [IDX_W-1:0]  cb_wr_idx,
    input  logic [WAY_W-1:0]  cb_wr_way,
    input  logic [SLOT_W-1:0] cb_wr_slot,
    input  logic              cb_wr_valid,
    input  logic [TS_W-1:0]   cb_wr_ts,
    input  logic              start,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              busy,
    output logic              done,
    output logic              evict_valid,
    output logic [WAY_W-1:0]  evict_way,
    output logic [SLOT_W-1:0] evict_slot,
    output logic              evict_live,
    output logic              tag_rd_en,
    output logic [WAY_W-1:0]  tag_rd_way,
    output logic [SLOT_W-1:0] tag_rd_slot,
    input  logic              tag_rd_valid,
    input  logic [TAG_W-1:0]  tag_rd_tag,
    input  logic [TS_W-1:0]   tag_rd_ts,
    output logic              tag_wr_en,
    output logic [WAY_W-1:0]  tag_wr_way,
    output logic [SLOT_W-1:0] tag_wr_slot,
    output logic              tag_wr_valid,
    output logic [TAG_W-1:0]  tag_wr_tag,
    output logic [TS_W-1:0]   tag_wr_ts
);

    import tsv_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [IDX_W-1:0] ROOTS    = IDX_W'(WAYS);
    localparam logic [IDX_W-1:0] FANOUT   = IDX_W'(WAYS - 1);

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [TS_W-1:0]  ts;
    } line_t;

    phase_e           phase_q;
    logic [IDX_W-1:0] scan_q;
    logic [IDX_W-1:0] cur_q;
    logic [TS_W-1:0]  ref_q;
    logic [TAG_W-1:0] tag_q;

    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  par_idx;
    logic [IDX_W-1:0]  win_idx;
    logic [WAY_W-1:0]  ent_way;
    logic [SLOT_W-1:0] ent_slot;
    logic              ent_vld;
    logic [TS_W-1:0]   ent_ts;
    logic              cur_is_root;
    logic              par_is_root;
    line_t             wr_line;

    // ---------------- global time ----------------
    tsv_stamp_clock #(.TS_W(TS_W)) u_clock (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .place(done),
        .now  (now_ts)
    );

    // ---------------- candidate buffer (single read port) ----------------
    tsv_cand_store #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .WAY_W(WAY_W), .SLOT_W(SLOT_W), .TS_W(TS_W)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cb_wr_en),
        .wr_idx (cb_wr_idx),
        .wr_way (cb_wr_way),
        .wr_slot(cb_wr_slot),
        .wr_vld (cb_wr_valid),
        .wr_ts  (cb_wr_ts),
        .rd_idx (rd_idx),
        .rd_way (ent_way),
        .rd_slot(ent_slot),
        .rd_vld (ent_vld),
        .rd_ts  (ent_ts)
    );

    // ---------------- age comparator ----------------
    tsv_oldest_pick #(.IDX_W(IDX_W), .TS_W(TS_W)) u_pick (
        .clk    (clk),
        .rst    (rst),
        .step   (phase_q == ST_SCAN),
        .first  (scan_q == '0),
        .idx    (scan_q),
        .ref_ts (ref_q),
        .cand_ts(ent_ts),
        .win_idx(win_idx)
    );

    // ---------------- tree navigation ----------------
    assign par_idx     = (cur_q - ROOTS) / FANOUT;
    assign cur_is_root = cur_q < ROOTS;
    assign par_is_root = par_idx < ROOTS;

    // The single buffer port serves the scan, the parent lookup and the write target.
    always_comb begin
        rd_idx = cur_q;
        if (phase_q == ST_SCAN) begin
            rd_idx = scan_q;
        end else if (phase_q == ST_READ) begin
            rd_idx = par_idx;
        end
    end

    // ---------------- sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ST_IDLE;
            scan_q  <= '0;
            cur_q   <= '0;
            ref_q   <= '0;
            tag_q   <= '0;
        end else begin
            case (phase_q)
                ST_IDLE: begin
                    if (start) begin
                        ref_q   <= now_ts;
                        tag_q   <= req_tag;
                        scan_q  <= '0;
                        phase_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (!ent_vld) begin
                        cur_q   <= scan_q;
                        phase_q <= ST_EVICT;
                    end else if (scan_q == LAST_IDX) begin
                        cur_q   <= win_idx;
                        phase_q <= ST_EVICT;
                    end else begin
                        scan_q <= scan_q + IDX_W'(1);
                    end
                end
                ST_EVICT: phase_q <= cur_is_root ? ST_PLACE : ST_READ;
                ST_READ:  phase_q <= ST_MOVE;
                ST_MOVE: begin
                    cur_q   <= par_idx;
                    phase_q <= par_is_root ? ST_PLACE : ST_READ;
                end
                ST_PLACE: phase_q <= ST_IDLE;
                default:  phase_q <= ST_IDLE;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        if (phase_q == ST_PLACE) begin
            wr_line = '{vld: 1'b1, tag: tag_q, ts: now_ts};
        end else begin
            wr_line = '{vld: tag_rd_valid, tag: tag_rd_tag, ts: tag_rd_ts};
        end
    end

    assign busy         = phase_q != ST_IDLE;
    assign done         = phase_q == ST_PLACE;
    assign evict_valid  = phase_q == ST_EVICT;
    assign evict_way    = ent_way;
    assign evict_slot   = ent_slot;
    assign evict_live   = ent_vld;
    assign tag_rd_en    = phase_q == ST_READ;
    assign tag_rd_way   = ent_way;
    assign tag_rd_slot  = ent_slot;
    assign tag_wr_en    = (phase_q == ST_MOVE) || (phase_q == ST_PLACE);
    assign tag_wr_way   = ent_way;
    assign tag_wr_slot  = ent_slot;
    assign tag_wr_valid = wr_line.vld;
    assign tag_wr_tag   = wr_line.tag;
    assign tag_wr_ts    = wr_line.ts;

    // ---------------- assertions ----------------
    // R8: placement is a write
    p_done_writes_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> tag_wr_en);

    // R8: operation ends right after placement
    p_done_ends_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R8: accepted start raises busy
    p_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R10: each read feeds a relocation write in the next cycle
    p_read_feeds_move_r10: assert property (@(posedge clk) disable iff (rst)
        tag_rd_en |=> (tag_wr_en && !done));

    // R5: the victim is reported for a single cycle
    p_evict_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        evict_valid |=> !evict_valid);

    // R7: the placed line is valid
    p_place_valid_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> tag_wr_valid);

endmodule

// File: tb/test_tsv_evict_relocator.sv
module test_tsv_evict_relocator;

    localparam int WAYS   = 4;
    localparam int LEVELS = 3;
    localparam int SLOT_W = 6;
    localparam int TAG_W  = 12;
    localparam int TS_W   = 16;
    localparam int DEPTH  = 52;
    localparam int IDX_W  = 6;
    localparam int WAY_W  = 2;
    localparam int NSLOT  = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              tick = 1'b0;
    logic [TS_W-1:0]   now_ts;
    logic              cb_wr_en = 1'b0;
    logic [IDX_W-1:0]  cb_wr_idx = '0;
    logic [WAY_W-1:0]  cb_wr_way = '0;
    logic [SLOT_W-1:0] cb_wr_slot = '0;
    logic              cb_wr_valid = 1'b0;
    logic [TS_W-1:0]   cb_wr_ts = '0;
    logic              start = 1'b0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              busy, done, evict_valid, evict_live;
    logic [WAY_W-1:0]  evict_way;
    logic [SLOT_W-1:0] evict_slot;
    logic              tag_rd_en;
    logic [WAY_W-1:0]  tag_rd_way;
    logic [SLOT_W-1:0] tag_rd_slot;
    logic              tag_rd_valid = 1'b0;
    logic [TAG_W-1:0]  tag_rd_tag = '0;
    logic [TS_W-1:0]   tag_rd_ts = '0;
    logic              tag_wr_en;
    logic [WAY_W-1:0]  tag_wr_way;
    logic [SLOT_W-1:0] tag_wr_slot;
    logic              tag_wr_valid;
    logic [TAG_W-1:0]  tag_wr_tag;
    logic [TS_W-1:0]   tag_wr_ts;

    tsv_evict_relocator #(
        .WAYS(WAYS), .LEVELS(LEVELS), .SLOT_W(SLOT_W), .TAG_W(TAG_W), .TS_W(TS_W)
    ) i_tsv_evict_relocator (
        .clk(clk), .rst(rst), .tick(tick), .now_ts(now_ts),
        .cb_wr_en(cb_wr_en), .cb_wr_idx(cb_wr_idx), .cb_wr_way(cb_wr_way),
        .cb_wr_slot(cb_wr_slot), .cb_wr_valid(cb_wr_valid), .cb_wr_ts(cb_wr_ts),
        .start(start), .req_tag(req_tag), .busy(busy), .done(done),
        .evict_valid(evict_valid), .evict_way(evict_way), .evict_slot(evict_slot),
        .evict_live(evict_live),
        .tag_rd_en(tag_rd_en), .tag_rd_way(tag_rd_way), .tag_rd_slot(tag_rd_slot),
        .tag_rd_valid(tag_rd_valid), .tag_rd_tag(tag_rd_tag), .tag_rd_ts(tag_rd_ts),
        .tag_wr_en(tag_wr_en), .tag_wr_way(tag_wr_way), .tag_wr_slot(tag_wr_slot),
        .tag_wr_valid(tag_wr_valid), .tag_wr_tag(tag_wr_tag), .tag_wr_ts(tag_wr_ts)
    );

    // ---------------- tag store model: one-cycle read latency ----------------
    logic            mv [WAYS][NSLOT];
    logic [TAG_W-1:0] mt [WAYS][NSLOT];
    logic [TS_W-1:0]  ms [WAYS][NSLOT];

    always @(posedge clk) begin
        if (tag_rd_en) begin
            tag_rd_valid <= mv[tag_rd_way][tag_rd_slot];
            tag_rd_tag   <= mt[tag_rd_way][tag_rd_slot];
            tag_rd_ts    <= ms[tag_rd_way][tag_rd_slot];
        end
        if (tag_wr_en) begin
            mv[tag_wr_way][tag_wr_slot] <= tag_wr_valid;
            mt[tag_wr_way][tag_wr_slot] <= tag_wr_tag;
            ms[tag_wr_way][tag_wr_slot] <= tag_wr_ts;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit is_evict;
        bit is_place;
        int way;
        int slot;
        bit vld;
        int tag;
        int ts;
    } item_t;

    item_t exp_q[$];
    item_t it;
    int    n_cmp = 0;
    int    n_bad = 0;
    int    model_now = 0;
    bit    last_rd = 1'b0;
    bit    bv [DEPTH];
    int    bs [DEPTH];

    task automatic chk(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: samples away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (evict_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected victim report", 1, 0);
                end else begin
                    it = exp_q.pop_front();
                    chk(it.is_evict, "R5 victim report out of order", 0, 1);
                    chk(int'(evict_way) == it.way, "R3 victim way", int'(evict_way), it.way);
                    chk(int'(evict_slot) == it.slot, "R3 victim slot", int'(evict_slot), it.slot);
                    chk(evict_live == it.vld, "R4 victim live flag", int'(evict_live), int'(it.vld));
                end
            end
            if (tag_wr_en) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected tag write", int'(tag_wr_slot), 0);
                end else begin
                    it = exp_q.pop_front();
                    chk(!it.is_evict, "R5 write before victim report", 1, 0);
                    chk(int'(tag_wr_way) == it.way && int'(tag_wr_slot) == it.slot,
                        "R6 write pointer", int'(tag_wr_way) * NSLOT + int'(tag_wr_slot),
                        it.way * NSLOT + it.slot);
                    chk(done == it.is_place, "R8 done on final write", int'(done), int'(it.is_place));
                    chk(busy, "R8 busy during write", int'(busy), 1);
                    if (it.is_place) begin
                        chk(tag_wr_valid && int'(tag_wr_tag) == it.tag, "R7 placed tag",
                            int'(tag_wr_tag), it.tag);
                        chk(int'(tag_wr_ts) == model_now, "R7 placed timestamp",
                            int'(tag_wr_ts), model_now);
                        chk(int'(now_ts) == model_now, "R2 counter at placement",
                            int'(now_ts), model_now);
                    end else begin
                        chk(last_rd, "R10 read before relocation", int'(last_rd), 1);
                        chk(tag_wr_valid == it.vld && int'(tag_wr_tag) == it.tag &&
                            int'(tag_wr_ts) == it.ts, "R6 relocated line",
                            int'(tag_wr_tag) * 65536 + int'(tag_wr_ts), it.tag * 65536 + it.ts);
                    end
                end
            end
            last_rd   = tag_rd_en;
            model_now = (model_now + int'(tick) + int'(done)) % 65536;
        end
    end

    // ---------------- driver ----------------
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic set_cand(int i, bit v, int ts);
        bv[i] = v;
        bs[i] = ts % 65536;
        mv[i % WAYS][i] = v;
        mt[i % WAYS][i] = TAG_W'(i + 256);
        ms[i % WAYS][i] = TS_W'(bs[i]);
    endtask

    task automatic load_buf();
        for (int i = 0; i < DEPTH; i++) begin
            cyc();
            cb_wr_en    = 1'b1;
            cb_wr_idx   = IDX_W'(i);
            cb_wr_way   = WAY_W'(i % WAYS);
            cb_wr_slot  = SLOT_W'(i);
            cb_wr_valid = bv[i];
            cb_wr_ts    = TS_W'(bs[i]);
        end
        cyc();
        cb_wr_en = 1'b0;
    endtask

    task automatic run_op(int tag, bit poke);
        int    ref_ts;
        int    v;
        int    best_age;
        int    cur;
        int    p;
        int    age;
        item_t e;
        cyc();
        ref_ts   = model_now;
        v        = -1;
        best_age = -1;
        for (int i = 0; i < DEPTH; i++) begin
            if (v < 0 || bv[v]) begin
                if (!bv[i]) begin
                    v = i;
                end else begin
                    age = (ref_ts - bs[i] + 65536) % 65536;
                    if (age > best_age) begin
                        best_age = age;
                        v = i;
                    end
                end
            end
        end
        e = '{is_evict: 1'b1, is_place: 1'b0, way: v % WAYS, slot: v, vld: bv[v], tag: 0, ts: 0};
        exp_q.push_back(e);
        cur = v;
        while (cur >= WAYS) begin
            p = (cur - WAYS) / (WAYS - 1);
            e = '{is_evict: 1'b0, is_place: 1'b0, way: cur % WAYS, slot: cur,
                  vld: mv[p % WAYS][p], tag: int'(mt[p % WAYS][p]), ts: int'(ms[p % WAYS][p])};
            exp_q.push_back(e);
            cur = p;
        end
        e = '{is_evict: 1'b0, is_place: 1'b1, way: cur % WAYS, slot: cur, vld: 1'b1, tag: tag, ts: 0};
        exp_q.push_back(e);
        start   = 1'b1;
        req_tag = TAG_W'(tag);
        cyc();
        start = 1'b0;
        chk(busy, "R8 busy after start", int'(busy), 1);
        if (poke) begin
            repeat (3) cyc();
            start   = 1'b1;
            req_tag = TAG_W'(tag ^ 12'hFFF);
            cyc();
            start = 1'b0;
        end
        while (exp_q.size() != 0) cyc();
        chk(!busy && !done, "R8 idle after placement", int'(busy), 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int need;
        for (int w = 0; w < WAYS; w++) begin
            for (int s = 0; s < NSLOT; s++) begin
                mv[w][s] = 1'b0;
                mt[w][s] = '0;
                ms[w][s] = '0;
            end
        end
        repeat (3) cyc();
        // R1: reset state
        chk(!busy && !done && !evict_valid, "R1 control outputs in reset", int'(busy), 0);
        chk(!tag_wr_en && !tag_rd_en, "R1 no tag access in reset", int'(tag_wr_en), 0);
        chk(now_ts == 0, "R1 time in reset", int'(now_ts), 0);
        rst = 1'b0;
        cyc();
        chk(!busy && now_ts == 0, "R1 state after reset", int'(now_ts), 0);

        // R2: plain ticking
        tick = 1'b1;
        repeat (1000) cyc();
        tick = 1'b0;
        cyc();
        chk(int'(now_ts) == 1000, "R2 tick count", int'(now_ts), 1000);

        // R3 R6: deep victim (index 40 -> 12 -> 2)
        for (int i = 0; i < DEPTH; i++) set_cand(i, 1'b1, 500 + i * 7);
        set_cand(40, 1'b1, 100);
        load_buf();
        run_op(12'h0A1, 1'b0);

        // R3 R7: first-level victim, no relocation
        for (int i = 0; i < DEPTH; i++) set_cand(i, 1'b1, 700 + i);
        set_cand(3, 1'b1, 50);
        load_buf();
        run_op(12'h0B2, 1'b0);

        // R3: equal ages, lower index wins (20 -> 5 -> 0)
        for (int i = 0; i < DEPTH; i++) set_cand(i, 1'b1, 800);
        set_cand(20, 1'b1, 60);
        set_cand(45, 1'b1, 60);
        load_buf();
        run_op(12'h0C3, 1'b0);

        // R4: first invalid wins over an older valid entry (30 -> 8 -> 1)
        for (int i = 0; i < DEPTH; i++) set_cand(i, 1'b1, 900);
        set_cand(10, 1'b1, 1);
        set_cand(30, 1'b0, 950);
        set_cand(50, 1'b0, 950);
        load_buf();
        run_op(12'h0D4, 1'b0);

        // R9: a second start during the operation is ignored
        for (int i = 0; i < DEPTH; i++) set_cand(i, 1'b1, 600 + i * 3);
        set_cand(41, 1'b1, 20);
        load_buf();
        run_op(12'h0E5, 1'b1);
        repeat (60) cyc();
        chk(!busy, "R9 no second operation", int'(busy), 0);

        // R2 R7: access tick coincides with placement
        for (int i = 0; i < DEPTH; i++) set_cand(i, 1'b1, 1000 - i);
        load_buf();
        tick = 1'b1;
        run_op(12'h0F6, 1'b0);
        tick = 1'b0;
        cyc();
        chk(int'(now_ts) == model_now, "R2 double advance", int'(now_ts), model_now);

        // R2 R3: wrap the counter; a numerically large stamp is the oldest
        need = 65536 - model_now + 40;
        tick = 1'b1;
        repeat (need) cyc();
        tick = 1'b0;
        cyc();
        chk(int'(now_ts) == model_now && model_now < 100, "R2 wraparound", int'(now_ts), model_now);
        for (int i = 0; i < DEPTH; i++) set_cand(i, 1'b1, (model_now - 5 + 65536) % 65536);
        set_cand(33, 1'b1, 16'hFFF0);
        load_buf();
        run_op(12'h107, 1'b0);

        // R3 R4 R6: pseudo-random stamps and validity
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < DEPTH; i++) begin
                set_cand(i, ($urandom % 16) != 0,
                         (model_now + 65536 - 1 - int'($urandom % 3000)) % 65536);
            end
            load_buf();
            run_op(12'h200 + k, 1'b0);
        end

        repeat (5) cyc();
        chk(exp_q.size() == 0, "R5 all expected events seen", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule